// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Unit

This block sits between a 32-bit core and a byte-addressed data memory that has one 32-bit word port with a write-enable bit per byte lane. For a store, the core gives the byte address, the access size and the source register. The block returns the word-aligned memory address, a write word with the data copied onto every lane it could land on, and the lane enables.

For a load, the block records the size, the byte offset and the signedness of the request. The memory returns its word one cycle later. In that cycle the block picks the addressed byte or halfword out of the word and widens it to 32 bits, either with the sign bit or with zeros. Lane order is big-endian: byte offset 0 is the most significant byte of the word, bits 31:24.

Accesses whose address does not suit their size are flagged as misaligned. Such an access enables no memory cycle and produces no load response.

Top module: `be_lane_unit`

## Requirements
- R1: While a request is presented, `mem_addr` equals `req_addr` with its two low bits forced to zero.
- R2: The size codes are 0 for byte, 1 for halfword, 2 for word and 3 for illegal. A request is misaligned when it is a halfword with address bit 0 set, a word with either of address bits 1:0 set, or uses size code 3. Byte accesses are never misaligned. A misaligned request raises `misalign`, keeps `mem_en` low and keeps `mem_wbe` at zero.
- R3: A byte store at offset k (k = address bits 1:0) sets only `mem_wbe` bit (3-k), where bit 3 is the lane for data bits 31:24. It also drives the low byte of `req_wdata` onto all four lanes of `mem_wdata`.
- R4: A halfword store at offset 0 sets `mem_wbe` to 4'b1100, and one at offset 2 sets it to 4'b0011. In both cases `mem_wdata` carries the low 16 bits of `req_wdata` twice.
- R5: An aligned word store sets `mem_wbe` to 4'b1111 and passes `req_wdata` through unchanged.
- R6: An aligned load raises `mem_en` and keeps `mem_wbe` at zero.
- R7: `rsp_valid` is high in the cycle after an aligned load request, and only then. Stores and misaligned loads never produce it.
- R8: A byte load at offset k returns bits [31-8k:24-8k] of `mem_rdata`, as seen in the response cycle. The upper 24 bits copy bit 7 of that byte when `req_unsigned` was 0, and are zero when it was 1.
- R9: A halfword load returns `mem_rdata[31:16]` at offset 0 and `mem_rdata[15:0]` at offset 2. The upper 16 bits are filled by the same signedness rule as R8.
- R10: A word load returns `mem_rdata` unchanged.
- R11: While reset is low, and after it, until a load is issued, `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_unsigned | input | 1 | Load widening: 1 zero-fill, 0 sign-fill |
| req_wdata | input | 32 | Store source register value |
| mem_en | output | 1 | Memory access enable |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wbe | output | 4 | Per-lane write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-replicated write word |
| mem_rdata | input | 32 | Word returned by memory one cycle after a load |
| misalign | output | 1 | Current request is misaligned |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | 32 | Widened load result |

## Verification
The store outputs, `mem_addr`, `mem_en` and `misalign` are combinational, so the bench checks them one time unit after it drives a request, in the same cycle. A load result is due in the cycle after its request. The bench acts as the memory and presents the word together with the request, then holds it through the next cycle. The driver queues the expected result for each aligned load. A monitor samples a quarter period after every rising edge and takes the next queued value whenever `rsp_valid` is high. A response with nothing queued, or values still queued at the end of the run, counts as a failure. Explicit checks after misaligned loads confirm that no response appears.

// File: rtl/be_lane_pkg.sv
package be_lane_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = 4;
  localparam int unsigned WORD_W = BYTE_W * LANES;
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  // Alignment rule per access size.
  function automatic logic off_bad(acc_size_e sz, logic [OFF_W-1:0] off);
    logic r;
    unique case (sz)
      SZ_BYTE: r = 1'b0;
      SZ_HALF: r = off[0];
      SZ_WORD: r = |off;
      default: r = 1'b1;
    endcase
    return r;
  endfunction

  // Big-endian lane enables: offset 0 maps to the top lane.
  function automatic logic [LANES-1:0] lane_mask(acc_size_e sz, logic [OFF_W-1:0] off);
    logic [LANES-1:0] m;
    m = '0;
    unique case (sz)
      SZ_BYTE: m[LANES-1-int'(off)] = 1'b1;
      SZ_HALF: begin
        for (int i = 0; i < LANES; i++)
          m[i] = ((i / 2) == (1 - int'(off[1])));
      end
      SZ_WORD: m = '1;
      default: m = '0;
    endcase
    return m;
  endfunction

  // Select and widen the addressed piece of a returned word.
  function automatic logic [WORD_W-1:0] pick_load(acc_size_e sz, logic [OFF_W-1:0] off,
                                                  logic uns, logic [WORD_W-1:0] w);
    logic [BYTE_W-1:0] b;
    logic [HALF_W-1:0] h;
    logic [WORD_W-1:0] r;
    b = w[(LANES-1-int'(off))*BYTE_W +: BYTE_W];
    h = w[(1-int'(off[1]))*HALF_W +: HALF_W];
    unique case (sz)
      SZ_BYTE: r = {{(WORD_W-BYTE_W){b[BYTE_W-1] & ~uns}}, b};
      SZ_HALF: r = {{(WORD_W-HALF_W){h[HALF_W-1] & ~uns}}, h};
      default: r = w;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/be_align_chk.sv
module be_align_chk
  import be_lane_pkg::*;
(
  input  logic             active,
  input  acc_size_e        size,
  input  logic [OFF_W-1:0] off,
  output logic             bad
);
  assign bad = active & off_bad(size, off);
endmodule

// File: rtl/be_store_lane.sv
module be_store_lane
  import be_lane_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic [WORD_W-1:0] data,
  output logic [LANES-1:0]  wbe,
  output logic [WORD_W-1:0] wdata
);
  assign wbe = active ? lane_mask(size, off) : '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wdata[g*BYTE_W +: BYTE_W] =
      (size == SZ_BYTE) ? data[BYTE_W-1:0] :
      (size == SZ_HALF) ? data[(g % 2)*BYTE_W +: BYTE_W] :
                          data[g*BYTE_W +: BYTE_W];
  end

  assert_byte_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && size == SZ_BYTE) |-> ($countones(wbe) == 1 && wbe[LANES-1-int'(off)]));

  assert_half_two_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && size == SZ_HALF) |-> ($countones(wbe) == 2 &&
      wdata[WORD_W-1:HALF_W] == data[HALF_W-1:0]));
endmodule

// File: rtl/be_load_lane.sv
module be_load_lane
  import be_lane_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic              uns,
  input  logic [WORD_W-1:0] rdata,
  output logic              vld,
  output logic [WORD_W-1:0] result
);
  acc_size_e        cap_size;
  logic [OFF_W-1:0] cap_off;
  logic             cap_uns;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld      <= 1'b0;
      cap_size <= SZ_WORD;
      cap_off  <= '0;
      cap_uns  <= 1'b0;
    end else begin
      vld <= issue;
      if (issue) begin
        cap_size <= size;
        cap_off  <= off;
        cap_uns  <= uns;
      end
    end
  end

  assign result = pick_load(cap_size, cap_off, cap_uns, rdata);

  assert_rsp_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> vld);

  assert_rsp_only_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> $past(issue));

  assert_zero_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && cap_uns && cap_size == SZ_BYTE) |-> result[WORD_W-1:BYTE_W] == '0);

  assert_word_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && cap_size == SZ_WORD) |-> result == rdata);
endmodule

// File: rtl/be_lane_unit.sv
module be_lane_unit
  import be_lane_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              mem_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_wbe,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              misalign,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data
);
  acc_size_e        size_q;
  logic [OFF_W-1:0] off;
  logic             store_go;
  logic             load_go;

  assign size_q   = acc_size_e'(req_size);
  assign off      = req_addr[OFF_W-1:0];
  assign mem_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  be_align_chk u_align (
    .active (req_valid),
    .size   (size_q),
    .off    (off),
    .bad    (misalign)
  );

  assign mem_en   = req_valid & ~misalign;
  assign store_go = mem_en & req_write;
  assign load_go  = mem_en & ~req_write;

  be_store_lane u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (store_go),
    .size   (size_q),
    .off    (off),
    .data   (req_wdata),
    .wbe    (mem_wbe),
    .wdata  (mem_wdata)
  );

  be_load_lane u_load (
    .clk    (clk),
    .rst_n  (rst_n),
    .issue  (load_go),
    .size   (size_q),
    .off    (off),
    .uns    (req_unsigned),
    .rdata  (mem_rdata),
    .vld    (rsp_valid),
    .result (rsp_data)
  );

  assert_misalign_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (!mem_en && mem_wbe == '0));

  assert_load_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> mem_wbe == '0);

  assert_word_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (store_go && size_q == SZ_WORD) |-> (mem_wbe == '1 && mem_wdata == req_wdata));
endmodule

// File: tb/be_lane_unit_bench.sv
module be_lane_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid, req_write, req_unsigned;
  logic [31:0] req_addr, req_wdata, mem_rdata;
  logic [1:0]  req_size;
  logic        mem_en, misalign, rsp_valid;
  logic [31:0] mem_addr, mem_wdata, rsp_data;
  logic [3:0]  mem_wbe;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  be_lane_unit u_be_lane_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_unsigned(req_unsigned),
    .req_wdata(req_wdata), .mem_en(mem_en), .mem_addr(mem_addr),
    .mem_wbe(mem_wbe), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .misalign(misalign), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit bench_bad(int sz, logic [31:0] a);
    if (sz == 0) return 1'b0;
    if (sz == 1) return (a % 2) != 0;
    if (sz == 2) return (a % 4) != 0;
    return 1'b1;
  endfunction

  function automatic logic [31:0] bench_load(int sz, int k, bit uns, logic [31:0] w);
    logic [31:0] v;
    if (sz == 0) begin
      v = (w >> (24 - 8*k)) & 32'hFF;
      if (!uns && v[7]) v = v | 32'hFFFF_FF00;
    end else if (sz == 1) begin
      v = (w >> ((k == 0) ? 16 : 0)) & 32'hFFFF;
      if (!uns && v[15]) v = v | 32'hFFFF_0000;
    end else v = w;
    return v;
  endfunction

  task automatic store(logic [31:0] a, int sz, logic [31:0] d, string tag);
    bit bad;
    int k;
    logic [3:0]  eb;
    logic [31:0] ew;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a;
    req_size = 2'(sz); req_unsigned = 1'b0; req_wdata = d;
    #1;
    bad = bench_bad(sz, a);
    k = int'(a % 4);
    chk({tag, " R1 addr"}, mem_addr, a & 32'hFFFF_FFFC);
    chk({tag, " R2 misalign"}, {31'd0, misalign}, {31'd0, bad});
    chk({tag, " R2 en"}, {31'd0, mem_en}, {31'd0, !bad});
    if (bad) eb = 4'b0000;
    else if (sz == 0) eb = 4'b1000 >> k;
    else if (sz == 1) eb = (k == 0) ? 4'b1100 : 4'b0011;
    else eb = 4'b1111;
    chk({tag, " lanes"}, {28'd0, mem_wbe}, {28'd0, eb});
    if (!bad) begin
      if (sz == 0) ew = 32'h0101_0101 * d[7:0];
      else if (sz == 1) ew = 32'h0001_0001 * d[15:0];
      else ew = d;
      chk({tag, " wdata"}, mem_wdata, ew);
    end
  endtask

  task automatic load(logic [31:0] a, int sz, bit uns, logic [31:0] w, string tag);
    bit bad;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    req_size = 2'(sz); req_unsigned = uns; req_wdata = 32'hDEAD_BEEF;
    mem_rdata = w;
    #1;
    bad = bench_bad(sz, a);
    chk({tag, " R6 no lanes"}, {28'd0, mem_wbe}, 32'd0);
    chk({tag, " R6 en"}, {31'd0, mem_en}, {31'd0, !bad});
    if (!bad) begin
      exp_q.push_back(bench_load(sz, int'(a % 4), uns, w));
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  // Monitor: compare each load response against the scoreboard.
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk("R7 unexpected response", 32'd1, 32'd0);
      end else begin
        chk(tag_q.pop_front(), rsp_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD*200000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = '0;
    req_unsigned = 1'b0; req_wdata = '0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset valid", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle valid", {31'd0, rsp_valid}, 32'd0);

    for (int k = 0; k < 4; k++) store(32'h0000_1000 + k, 0, 32'h1234_5600 + k*17, "R3 byte store");
    store(32'h0000_2000, 1, 32'hAAAA_BEEF, "R4 half store off0");
    store(32'h0000_2002, 1, 32'h5555_C0DE, "R4 half store off2");
    store(32'h0000_3000, 2, 32'h89AB_CDEF, "R5 word store");
    store(32'h0000_2001, 1, 32'h1111_2222, "R2 half odd");
    store(32'h0000_3002, 2, 32'h3333_4444, "R2 word off2");
    store(32'h0000_3003, 2, 32'h5555_6666, "R2 word off3");
    store(32'h0000_4000, 3, 32'h7777_8888, "R2 illegal size");
    idle();
    @(posedge clk); #(CLK_PERIOD/4);
    chk("R7 no response after stores", {31'd0, rsp_valid}, 32'd0);

    for (int k = 0; k < 4; k++) begin
      load(32'h0000_5000 + k, 0, 1'b0, 32'h80_7F_F1_0E, "R8 byte signed");
      load(32'h0000_5000 + k, 0, 1'b1, 32'h80_7F_F1_0E, "R8 byte unsigned");
    end
    load(32'h0000_6000, 1, 1'b0, 32'h8001_7FFE, "R9 half signed off0");
    load(32'h0000_6002, 1, 1'b0, 32'h7FFE_8001, "R9 half signed off2");
    load(32'h0000_6000, 1, 1'b1, 32'hF00D_0000, "R9 half unsigned off0");
    load(32'h0000_6002, 1, 1'b1, 32'h0000_9ABC, "R9 half unsigned off2");
    load(32'h0000_6002, 1, 1'b0, 32'hFFFF_1234, "R9 half positive off2");
    load(32'h0000_7000, 2, 1'b0, 32'hCAFE_F00D, "R10 word");
    load(32'h0000_7004, 2, 1'b1, 32'h0123_4567, "R10 word unsigned flag");
    load(32'h0000_7002, 2, 1'b0, 32'h1111_1111, "R7 misaligned word load");
    idle();
    @(posedge clk); #(CLK_PERIOD/4);
    chk("R7 no response after misaligned load", {31'd0, rsp_valid}, 32'd0);
    load(32'h0000_7001, 1, 1'b0, 32'h2222_2222, "R7 misaligned half load");
    store(32'h0000_7008, 2, 32'h0BAD_F00D, "R7 store after load");
    @(posedge clk); #(CLK_PERIOD/4);
    chk("R7 no response after store", {31'd0, rsp_valid}, 32'd0);
    repeat (4) idle();
    chk("R7 drained scoreboard", exp_q.size(), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule